// File: doc/BRIEF.md
# NAND Read Prefetch FIFO Engine

This block sits between a 32-bit host bus and a byte-wide NAND data port and moves read data ahead of the host. Software first loads a configuration word and a byte count. It then writes a one to the control register. The engine then pulls bytes from the NAND port into a 64-byte FIFO until the FIFO is full or the count runs out. The host drains the FIFO as little-endian 32-bit words by reading anywhere inside the chip-select window that the engine is assigned to. A status word reports the FIFO fill level and the bytes still to be fetched.

The block decodes several chip-select windows, each with a programmable base and mask. While the enable bit is set, reads to the selected window are served from the FIFO. A separate direct-data register always performs a single-byte NAND read and never touches the FIFO. Reads to any window that is not rerouted also go straight to NAND. When the last byte has been fetched and the FIFO is empty, the engine drops its busy bit and pulses a completion output for one cycle.

Top module: `nandpf_top`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, `xfer_done` and `nand_rd` are low, and every window mask is 0. A window whose mask is 0 matches no address, and a read that hits no window returns 0 at once.
- R2: The register page is at 0xFFFF_0000. CFG1 (offset 0x00) keeps the enable bit at bit 7 and the direction bit at bit 0 (0 = read). It also keeps a 7-bit threshold at bits 14:8 and the window selector at bits 25:24. Other bits read 0. CFG2 (0x04) holds a 14-bit byte count in bits 13:0. Window i has its base at 0x20+8i and its mask at 0x24+8i. All of these registers read back what was written.
- R3: Writing 1 to bit 0 of CTRL (0x08) starts a transfer only when the engine is idle, enable=1 and direction=0. Starting loads the remaining count from CFG2 and empties the FIFO. CTRL bit 0 reads 1 while the engine is busy.
- R4: While busy, the engine reads one NAND byte per cycle in which `nand_rdy` is high, as long as bytes remain and the FIFO holds fewer than 64. Each byte fetched lowers the remaining count by one. The FIFO never holds more than 64 bytes.
- R5: STATUS (0x0C) gives the FIFO fill level in bits 30:24 and the remaining count in bits 13:0. Bit 16 is 1 when the threshold is nonzero and the fill level is at or above it. All other bits read 0.
- R6: While enable=1, a read that hits the selected window pops 4 bytes and returns them little-endian (oldest byte in bits 7:0). If fewer than 4 bytes are present, the read stalls (no `host_ack`) while fetching is still pending. Once no fetch is pending, it returns the bytes that are left with zeros above them.
- R7: A read of the direct register (0x10) performs one NAND byte read and returns the byte in bits 7:0, acknowledged with `nand_rdy`. It takes priority over engine fetches and leaves the FIFO level and the remaining count unchanged.
- R8: A window matches when (addr & mask) == (base & mask). A read to a window that is not selected, or to any window while enable=0, is a direct NAND access.
- R9: When the engine is busy, the remaining count is 0 and the FIFO is empty, CTRL clears to 0 and `xfer_done` is high for exactly one cycle. A zero-length start completes in the same way.
- R10: Writes to CFG1 and CFG2 have no effect while the engine is busy.
- R11: Writing 0 to CTRL bit 0 stops the engine at once. No further bytes are fetched, the remaining count holds its value, and no completion pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Byte address |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | Access completes on the rising edge where this is high |
| host_rdata | output | 32 | Read data, valid while `host_ack` is high |
| nand_rd | output | 1 | NAND byte read strobe |
| nand_rdy | input | 1 | NAND ready; a byte moves on each edge with `nand_rd` and `nand_rdy` high |
| nand_din | input | 8 | NAND read byte |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The bench fills the FIFO to exactly 64 bytes and checks the status word. A design that kept fetching past full would show a level above 64 or a remaining count below 36. It then issues a direct read into the full FIFO. A design that routed that read through the FIFO, or let it advance the count, would return FIFO data or a changed status. It drives a 6-byte transfer with the NAND held not-ready to show the word read stalling, then releases the NAND and takes a 2-byte tail that must come back zero-padded. A design that popped early would return stale bytes, and one that waited for 4 bytes would hang. It also checks that config writes during a transfer are dropped, that a stop holds the remaining count without a completion pulse, and that an unselected window and the disabled state both give direct NAND bytes.

// File: rtl/nandpf_pkg.sv
package nandpf_pkg;
  // Register offsets inside the register page
  localparam logic [7:0] OFS_CFG1   = 8'h00;
  localparam logic [7:0] OFS_CFG2   = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_DIRECT = 8'h10;
  localparam logic [7:0] OFS_WIN    = 8'h20;

  // Field positions
  localparam int CFG1_DIR_BIT = 0;
  localparam int CFG1_EN_BIT  = 7;
  localparam int CFG1_THR_LSB = 8;
  localparam int CFG1_SEL_LSB = 24;
  localparam int STAT_THR_BIT = 16;
  localparam int STAT_CNT_LSB = 24;

  typedef enum logic [1:0] {
    HOP_REG    = 2'd0,
    HOP_FIFO   = 2'd1,
    HOP_DIRECT = 2'd2
  } host_op_e;
endpackage

// File: rtl/nandpf_fifo.sv
module nandpf_fifo #(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             pop,
  input  logic [2:0]       pop_n,
  output logic [CNT_W-1:0] count,
  output logic [31:0]      dout
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (push) wptr_n = wptr_q + PTR_W'(1);
      if (pop)  rptr_n = rptr_q + PTR_W'(pop_n);
      cnt_n = cnt_q + CNT_W'(push) - (pop ? CNT_W'(pop_n) : CNT_W'(0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  // Storage has no reset; reads are gated by the fill level
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr_q] <= din;
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign dout[8*k +: 8] = (CNT_W'(k) < cnt_q) ? mem[rptr_q + PTR_W'(k)] : 8'h00;
  end

  assign count = cnt_q;
endmodule

// File: rtl/nandpf_csdec.sv
module nandpf_csdec #(
  parameter int NCS = 4
) (
  input  logic [31:0]           addr,
  input  logic [NCS-1:0][31:0]  base,
  input  logic [NCS-1:0][31:0]  mask,
  output logic [NCS-1:0]        hit
);
  for (genvar i = 0; i < NCS; i++) begin : g_win
    assign hit[i] = (mask[i] != 32'h0) && ((addr & mask[i]) == (base[i] & mask[i]));
  end
endmodule

// File: rtl/nandpf_top.sv
module nandpf_top
  import nandpf_pkg::*;
#(
  parameter int          NCS      = 4,
  parameter int          DEPTH    = 64,
  parameter int          LEN_W    = 14,
  parameter logic [23:0] REG_PAGE = 24'hFFFF00,
  localparam int CS_W  = $clog2(NCS),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [31:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic        host_ack,
  output logic [31:0] host_rdata,
  output logic        nand_rd,
  input  logic        nand_rdy,
  input  logic [7:0]  nand_din,
  output logic        xfer_done
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // Architectural state
  logic                     en_q, en_n, dir_q, dir_n, busy_q, busy_n, done_q, done_n;
  logic [CNT_W-1:0]         thr_q, thr_n;
  logic [CS_W-1:0]          sel_q, sel_n;
  logic [LEN_W-1:0]         len_q, len_n, remain_q, remain_n;
  logic [NCS-1:0][31:0]     base_q, base_n, mask_q, mask_n;

  // Decode
  logic             reg_hit, fifo_avail, direct_act, fetch, push, pop, flush, wr, fifo_route;
  logic [7:0]       ofs;
  logic [NCS-1:0]   cs_hit;
  host_op_e         op;
  logic [CNT_W-1:0] fifo_cnt;
  logic [31:0]      fifo_dout, reg_rd, stat;
  logic [2:0]       pop_n;

  nandpf_csdec #(.NCS(NCS)) csdec_i (
    .addr(host_addr), .base(base_q), .mask(mask_q), .hit(cs_hit)
  );

  assign reg_hit = (host_addr[31:8] == REG_PAGE);
  assign ofs     = host_addr[7:0];

  always_comb begin
    op = HOP_REG;
    if (!reg_hit && !host_we && en_q && cs_hit[sel_q])
      op = HOP_FIFO;
    else if (!host_we && ((reg_hit && ofs == OFS_DIRECT) || (!reg_hit && (|cs_hit))))
      op = HOP_DIRECT;
  end

  assign fifo_route = (op == HOP_FIFO);
  assign fifo_avail = (fifo_cnt >= CNT_W'(4)) ||
                      ((fifo_cnt != '0) && (!busy_q || remain_q == '0));
  assign host_ack   = host_req && (fifo_route ? fifo_avail :
                                   (op == HOP_DIRECT) ? nand_rdy : 1'b1);
  assign direct_act = host_req && (op == HOP_DIRECT);
  assign fetch      = busy_q && (remain_q != '0) && (fifo_cnt < CNT_W'(DEPTH)) && !direct_act;
  assign nand_rd    = direct_act || fetch;
  assign push       = fetch && nand_rdy;
  assign pop        = host_req && fifo_route && fifo_avail;
  assign pop_n      = (fifo_cnt >= CNT_W'(4)) ? 3'd4 : fifo_cnt[2:0];
  assign wr         = host_req && host_we && reg_hit;

  nandpf_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(srst_n), .flush(flush), .push(push), .din(nand_din),
    .pop(pop), .pop_n(pop_n), .count(fifo_cnt), .dout(fifo_dout)
  );

  // Status and register read mux
  always_comb begin
    stat = '0;
    stat[STAT_CNT_LSB +: CNT_W] = fifo_cnt;
    stat[STAT_THR_BIT]          = (thr_q != '0) && (fifo_cnt >= thr_q);
    stat[LEN_W-1:0]             = remain_q;
  end

  always_comb begin
    reg_rd = '0;
    case (ofs)
      OFS_CFG1: begin
        reg_rd[CFG1_DIR_BIT]               = dir_q;
        reg_rd[CFG1_EN_BIT]                = en_q;
        reg_rd[CFG1_THR_LSB +: CNT_W]      = thr_q;
        reg_rd[CFG1_SEL_LSB +: CS_W]       = sel_q;
      end
      OFS_CFG2: reg_rd[LEN_W-1:0] = len_q;
      OFS_CTRL: reg_rd[0]         = busy_q;
      OFS_STAT: reg_rd            = stat;
      default: begin
        for (int i = 0; i < NCS; i++) begin
          if (ofs == 8'(int'(OFS_WIN) + 8*i))     reg_rd = base_q[i];
          if (ofs == 8'(int'(OFS_WIN) + 8*i + 4)) reg_rd = mask_q[i];
        end
      end
    endcase
  end

  assign host_rdata = fifo_route          ? fifo_dout :
                      (op == HOP_DIRECT)  ? {24'h0, nand_din} :
                      (reg_hit && !host_we) ? reg_rd : 32'h0;

  // Next state
  always_comb begin
    en_n = en_q; dir_n = dir_q; thr_n = thr_q; sel_n = sel_q; len_n = len_q;
    busy_n = busy_q; remain_n = remain_q; base_n = base_q; mask_n = mask_q;
    flush = 1'b0;
    if (wr) begin
      case (ofs)
        OFS_CFG1: if (!busy_q) begin
          en_n  = host_wdata[CFG1_EN_BIT];
          dir_n = host_wdata[CFG1_DIR_BIT];
          thr_n = host_wdata[CFG1_THR_LSB +: CNT_W];
          sel_n = host_wdata[CFG1_SEL_LSB +: CS_W];
        end
        OFS_CFG2: if (!busy_q) len_n = host_wdata[LEN_W-1:0];
        OFS_CTRL: begin
          if (!host_wdata[0]) begin
            busy_n = 1'b0;
          end else if (!busy_q && en_q && !dir_q) begin
            busy_n   = 1'b1;
            remain_n = len_q;
            flush    = 1'b1;
          end
        end
        default: begin
          for (int i = 0; i < NCS; i++) begin
            if (ofs == 8'(int'(OFS_WIN) + 8*i))     base_n[i] = host_wdata;
            if (ofs == 8'(int'(OFS_WIN) + 8*i + 4)) mask_n[i] = host_wdata;
          end
        end
      endcase
    end
    if (push) remain_n = remain_q - LEN_W'(1);
    done_n = busy_q && (remain_q == '0) && (fifo_cnt == '0);
    if (done_n) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q <= 1'b0; dir_q <= 1'b0; thr_q <= '0; sel_q <= '0; len_q <= '0;
      busy_q <= 1'b0; remain_q <= '0; done_q <= 1'b0;
      base_q <= '0; mask_q <= '0;
    end else begin
      en_q <= en_n; dir_q <= dir_n; thr_q <= thr_n; sel_q <= sel_n; len_q <= len_n;
      busy_q <= busy_n; remain_q <= remain_n; done_q <= done_n;
      base_q <= base_n; mask_q <= mask_n;
    end
  end

  assign xfer_done = done_q;
endmodule

// File: rtl/nandpf_chk.sv
module nandpf_chk #(
  parameter int          DEPTH    = 64,
  parameter int          LEN_W    = 14,
  parameter int          CNT_W    = 7,
  parameter logic [23:0] REG_PAGE = 24'hFFFF00
) (
  input logic             clk,
  input logic             srst_n,
  input logic             host_req,
  input logic             host_we,
  input logic [31:0]      host_addr,
  input logic             host_ack,
  input logic             fifo_route,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             busy,
  input logic [LEN_W-1:0] remain,
  input logic             xfer_done
);
  logic direct_rd;
  assign direct_rd = host_req && !host_we && host_ack &&
                     (host_addr == {REG_PAGE, nandpf_pkg::OFS_DIRECT});

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!srst_n)
    fifo_cnt <= CNT_W'(DEPTH)); // R4
  AST_REMAIN_MONO: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && $past(busy)) |-> (remain <= $past(remain))); // R4
  AST_STALL_SHORT: assert property (@(posedge clk) disable iff (!srst_n)
    (host_req && fifo_route && fifo_cnt < CNT_W'(4) && busy && remain != '0) |-> !host_ack); // R6
  AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    direct_rd |=> (fifo_cnt == $past(fifo_cnt) && remain == $past(remain))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    xfer_done |=> !xfer_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!srst_n)
    xfer_done |-> (!busy && fifo_cnt == '0)); // R9
endmodule

bind nandpf_top nandpf_chk #(
  .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W), .REG_PAGE(REG_PAGE)
) chk_i (
  .clk(clk), .srst_n(srst_n), .host_req(host_req), .host_we(host_we),
  .host_addr(host_addr), .host_ack(host_ack), .fifo_route(fifo_route),
  .fifo_cnt(fifo_cnt), .busy(busy_q), .remain(remain_q), .xfer_done(xfer_done)
);

// File: tb/nandpf_top_tb.sv
`timescale 1ns/1ps
module nandpf_top_tb_top;
  localparam logic [31:0] RB   = 32'hFFFF_0000;
  localparam logic [31:0] CS0A = 32'h1000_0000;
  localparam logic [31:0] CS1A = 32'h2000_0000;

  // {we, offset, wdata, expected}
  localparam int NVEC = 13;
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 32'h0100_2080, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h0100_2080},
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h00, 32'h0,         32'h0300_7F81},
    {1'b1, 8'h04, 32'hFFFF_0010, 32'h0},
    {1'b0, 8'h04, 32'h0,         32'h0000_0010},
    {1'b1, 8'h20, 32'h1000_0000, 32'h0},
    {1'b0, 8'h20, 32'h0,         32'h1000_0000},
    {1'b1, 8'h24, 32'hFF00_0000, 32'h0},
    {1'b0, 8'h24, 32'h0,         32'hFF00_0000},
    {1'b1, 8'h28, 32'h2000_0000, 32'h0},
    {1'b1, 8'h2C, 32'hFF00_0000, 32'h0},
    {1'b0, 8'h2C, 32'h0,         32'hFF00_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0, nand_rdy = 1'b1;
  logic [31:0] host_addr = '0, host_wdata = '0;
  logic host_ack, nand_rd, xfer_done;
  logic [31:0] host_rdata;
  logic [7:0] nand_seq = 8'h00;

  int checks = 0, failures = 0, done_cnt = 0;
  bit dir_flag = 1'b0, finished = 1'b0;
  logic [7:0] exp_b [256];
  int exp_wr = 0, exp_rd = 0;

  always #4 clk = ~clk;

  nandpf_top dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_rdata(host_rdata), .nand_rd(nand_rd), .nand_rdy(nand_rdy),
    .nand_din(nand_seq), .xfer_done(xfer_done)
  );

  // NAND model: byte stream is a running counter
  always @(posedge clk) begin
    if (nand_rd && nand_rdy) begin
      if (!dir_flag && exp_wr < 256) begin
        exp_b[exp_wr] = nand_seq;
        exp_wr = exp_wr + 1;
      end
      nand_seq <= nand_seq + 8'd1;
    end
    if (xfer_done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [31:0] a, input int maxw,
                         output logic [31:0] d, output bit ok);
    ok = 1'b0; d = '0;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    for (int i = 0; i < maxw; i++) begin
      #1;
      if (host_ack) begin d = host_rdata; ok = 1'b1; break; end
      @(negedge clk);
    end
    if (ok) @(negedge clk);
    host_req = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input int valid);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      if (k < valid) w[8*k +: 8] = exp_b[exp_rd + k];
    return w;
  endfunction

  task automatic start_xfer();
    exp_wr = 0; exp_rd = 0;
    host_wr(RB + 32'h08, 32'h1);
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  eb;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 ctrl", {31'h0, 1'b0} | 32'(xfer_done) | 32'(nand_rd), 32'h0);
    host_rd(RB + 32'h08, 2, d, ok); chk("R1 ctrl reg", d, 32'h0);
    host_rd(RB + 32'h0C, 2, d, ok); chk("R1 status", d, 32'h0);
    eb = nand_seq;
    host_rd(CS0A, 2, d, ok);
    chk("R1 zero-mask window", {d[30:0], ok}, 32'h1);
    chk("R1 no nand access", 32'(nand_seq), 32'(eb));

    // R2: register table
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][72]) host_wr(RB + 32'(VEC[v][71:64]), VEC[v][63:32]);
      else begin
        host_rd(RB + 32'(VEC[v][71:64]), 2, d, ok);
        chk($sformatf("R2 vec%0d", v), d, VEC[v][31:0]);
      end
    end

    // R3/R4/R5: fill to full
    host_wr(RB + 32'h00, 32'h0000_0880);
    host_wr(RB + 32'h04, 32'd100);
    start_xfer();
    host_rd(RB + 32'h08, 2, d, ok); chk("R3 busy", d, 32'h1);
    repeat (80) @(negedge clk);
    host_rd(RB + 32'h0C, 2, d, ok); chk("R4 R5 full status", d, 32'h4001_0024);

    // R7: direct read while full
    dir_flag = 1'b1;
    host_rd(RB + 32'h10, 4, d, ok); chk("R7 direct byte", d, 32'h0000_0040);
    dir_flag = 1'b0;
    host_rd(RB + 32'h0C, 2, d, ok); chk("R7 status held", d, 32'h4001_0024);

    // R6/R9: drain 100 bytes
    for (int w = 0; w < 25; w++) begin
      host_rd(CS0A + 32'(4*w), 200, d, ok);
      chk($sformatf("R6 word%0d", w), d, exp_word(4));
      exp_rd += 4;
    end
    repeat (4) @(negedge clk);
    chk("R9 done count", 32'(done_cnt), 32'd1);
    host_rd(RB + 32'h08, 2, d, ok); chk("R9 ctrl clear", d, 32'h0);
    host_rd(RB + 32'h0C, 2, d, ok); chk("R9 status idle", d, 32'h0);

    // R6: stall and tail
    host_wr(RB + 32'h04, 32'd6);
    nand_rdy = 1'b0;
    start_xfer();
    host_rd(CS0A, 10, d, ok); chk("R6 stall", 32'(ok), 32'd0);
    nand_rdy = 1'b1;
    host_rd(CS0A, 50, d, ok); chk("R6 after stall", d, exp_word(4)); exp_rd += 4;
    host_rd(CS0A, 50, d, ok); chk("R6 tail", d, exp_word(2));
    repeat (4) @(negedge clk);
    chk("R9 tail done", 32'(done_cnt), 32'd2);

    // R10/R11: writes while busy, then stop
    host_wr(RB + 32'h04, 32'd100);
    nand_rdy = 1'b0;
    start_xfer();
    host_wr(RB + 32'h04, 32'd5);
    host_rd(RB + 32'h04, 2, d, ok); chk("R10 cfg2 held", d, 32'd100);
    host_wr(RB + 32'h00, 32'h0);
    host_rd(RB + 32'h00, 2, d, ok); chk("R10 cfg1 held", d, 32'h0000_0880);
    host_wr(RB + 32'h08, 32'h0);
    host_rd(RB + 32'h08, 2, d, ok); chk("R11 ctrl stop", d, 32'h0);
    nand_rdy = 1'b1;
    repeat (10) @(negedge clk);
    host_rd(RB + 32'h0C, 2, d, ok); chk("R11 remain held", d, 32'd100);
    chk("R11 no done", 32'(done_cnt), 32'd2);

    // R3: start refused
    host_wr(RB + 32'h00, 32'h0000_0881);
    host_wr(RB + 32'h08, 32'h1);
    host_rd(RB + 32'h08, 2, d, ok); chk("R3 dir=1 refused", d, 32'h0);
    host_wr(RB + 32'h00, 32'h0000_0800);
    host_wr(RB + 32'h08, 32'h1);
    host_rd(RB + 32'h08, 2, d, ok); chk("R3 en=0 refused", d, 32'h0);

    // R8: direct through windows
    eb = nand_seq; dir_flag = 1'b1;
    host_rd(CS0A, 4, d, ok); chk("R8 disabled window", d, 32'(eb));
    dir_flag = 1'b0;
    host_wr(RB + 32'h00, 32'h0000_0880);
    eb = nand_seq; dir_flag = 1'b1;
    host_rd(CS1A, 4, d, ok); chk("R8 unselected window", d, 32'(eb));
    dir_flag = 1'b0;
    host_rd(RB + 32'h0C, 2, d, ok); chk("R8 fifo untouched", d, 32'd100);

    // R8: selector picks window 1
    host_wr(RB + 32'h00, 32'h0100_0880);
    host_wr(RB + 32'h04, 32'd4);
    start_xfer();
    repeat (10) @(negedge clk);
    host_rd(CS1A + 32'h4, 20, d, ok); chk("R8 selected window 1", d, exp_word(4));
    repeat (4) @(negedge clk);
    chk("R9 sel1 done", 32'(done_cnt), 32'd3);

    // R9: zero-length
    host_wr(RB + 32'h04, 32'd0);
    start_xfer();
    repeat (5) @(negedge clk);
    host_rd(RB + 32'h08, 2, d, ok); chk("R9 zero-length ctrl", d, 32'h0);
    chk("R9 zero-length done", 32'(done_cnt), 32'd4);

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end
endmodule